// File: doc/BRIEF.md
# Isochronous Resource Lock Unit

This block holds the four isochronous resource registers of a serial-bus node: the bus manager identity, the remaining isochronous bandwidth and the two 32-bit words of the channel allocation bitmap. It carries out compare-and-swap lock requests on them. Each request gives a byte offset, an extended transaction code, a data value, an argument value and a flag that selects a 32-bit or a 64-bit lock. One clock later the unit returns a response code and the value the requester is owed. Any register update takes effect on the same clock edge, so each lock is atomic.

The three kinds of register follow different rules. The bus manager identity takes a plain compare-and-swap. Bandwidth treats the argument and data pair as an amount to allocate or free, and limits it to the 13-bit range. The channel words flip only the bits in which the argument and the data differ, and only when the register agrees with the argument on all of those bits. The channel in bit 0 of the high word stays reserved at all times. A bus-reset input restores all four registers in one cycle.

Top module: `irm_lock_unit`

## Requirements
- R1: Every request accepted while `bus_reset` is low raises `rsp_valid` for exactly one cycle, on the clock edge after the request. There is no response when no request is made. A request made while `bus_reset` is high gets no response.
- R2: Only the compare-swap code (`req_ext` = 2) is accepted as a 32-bit lock, and only at offsets 0x21C (bus manager ID), 0x220 (bandwidth), 0x224 (channels high) and 0x228 (channels low). A success answers `rsp_code` = 0. An offset not aligned to 4 bytes answers type error (`rsp_code` = 6).
- R3: The following 32-bit requests answer type error (6): requests to the other core registers (0x000, 0x004, 0x008, 0x00C, 0x018, 0x01C, 0x200, 0x204, 0x234), and requests to a resource register with a code other than compare-swap. The busy-timeout offset 0x210 and every unknown offset answer address error (7). Every error returns 0 in `rsp_old` and changes no register.
- R4: A bus manager ID lock returns the old value. The register takes the data value only when the old value equals the argument.
- R5: A bandwidth lock whose argument exceeds 0x1FFF returns the old value and changes nothing. Only the low 13 bits of the data value are used.
- R6: A bandwidth lock with argument >= data is an allocation of argument minus data. If that amount is no greater than the current value, the register drops by the amount and the argument is returned. Otherwise the current value is returned and the register is unchanged.
- R7: A bandwidth lock with argument < data is a release of data minus argument. If the current value plus that amount stays below 0x2000, the register grows by the amount and the argument is returned. Otherwise the current value is returned and the register is unchanged.
- R8: For a channel lock, the affected bits are argument XOR data. If the register matches the argument on every affected bit, those bits are inverted and the argument is returned. Otherwise the current register value is returned and the register is unchanged.
- R9: Bit 0 of the channels-high word (channel 31) is cleared from the data of every 32-bit or 64-bit channel lock before the lock is evaluated, so this bit stays 0 (allocated) at all times.
- R10: A 64-bit lock (`req_wide` = 1) with compare-swap at 0x224 applies the R8 rule to the pair {high, low} at once. A 64-bit lock at 0x224 with another code, or at 0x21C, 0x220, 0x210 or a core register, answers type error. A 64-bit lock at 0x228 or at an unknown offset answers address error.
- R11: Reset (`rst_n` low) and `bus_reset` both set bus manager ID 0x3F, bandwidth 4915 (0x1333), channels high 0xFFFFFFFE and channels low 0xFFFFFFFF, within one cycle.
- R12: The value of a 32-bit lock is returned in bits 31:0 of `rsp_old`, with bits 63:32 zero. The value of a 64-bit lock is returned as {high word, low word}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Restores the resource registers to their reset values |
| req_valid | input | 1 | A lock request is present this cycle |
| req_wide | input | 1 | 1 selects a 64-bit lock, 0 selects a 32-bit lock |
| req_offset | input | 12 | Byte offset in the register space |
| req_ext | input | 4 | Extended transaction code |
| req_data | input | 64 | Data value (32-bit locks use bits 31:0) |
| req_arg | input | 64 | Argument value (32-bit locks use bits 31:0) |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 4 | 0 complete, 6 type error, 7 address error |
| rsp_old | output | 64 | Returned old or argument value |

## Verification
Both the response and any register change come from the clock edge that samples the request. The response therefore belongs to the cycle after the request, and the next request already sees the new register value. The bench changes its inputs on the falling edge and reads the response at the following falling edge, half a period after the edge that produced it. It reads register contents only through locks whose outcome does not depend on the state they observe. For a request made under bus reset, it checks at that same point that no response appears.

// File: rtl/irm_pkg.sv
// Shared constants and types for the isochronous resource lock unit.
// Assumes byte offsets relative to the start of the core register space.
package irm_pkg;
    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_STATE_CLR = 12'h000;
    localparam logic [OFS_W-1:0] OFS_STATE_SET = 12'h004;
    localparam logic [OFS_W-1:0] OFS_NODE_IDS  = 12'h008;
    localparam logic [OFS_W-1:0] OFS_RST_START = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_SPLIT_HI  = 12'h018;
    localparam logic [OFS_W-1:0] OFS_SPLIT_LO  = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_CYC_TIME  = 12'h200;
    localparam logic [OFS_W-1:0] OFS_BUS_TIME  = 12'h204;
    localparam logic [OFS_W-1:0] OFS_BUSY_TO   = 12'h210;
    localparam logic [OFS_W-1:0] OFS_MGR_ID    = 12'h21C;
    localparam logic [OFS_W-1:0] OFS_BANDWIDTH = 12'h220;
    localparam logic [OFS_W-1:0] OFS_CHAN_HI   = 12'h224;
    localparam logic [OFS_W-1:0] OFS_CHAN_LO   = 12'h228;
    localparam logic [OFS_W-1:0] OFS_BCAST     = 12'h234;

    localparam logic [3:0] EXT_CMP_SWAP = 4'd2;

    localparam logic [3:0] RSP_DONE     = 4'd0;
    localparam logic [3:0] RSP_TYPE_ERR = 4'd6;
    localparam logic [3:0] RSP_ADDR_ERR = 4'd7;

    localparam logic [31:0] INIT_MGR_ID  = 32'h0000_003F;
    localparam logic [31:0] INIT_BW      = 32'd4915;
    localparam logic [31:0] INIT_CHAN_HI = 32'hFFFF_FFFE;
    localparam logic [31:0] INIT_CHAN_LO = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        TGT_MGR_ID,
        TGT_BW,
        TGT_CHAN_HI,
        TGT_CHAN_LO,
        TGT_CHAN_PAIR,
        TGT_TYPE_ERR,
        TGT_ADDR_ERR
    } target_e;
endpackage

// File: rtl/irm_decode.sv
// Request classifier: maps offset, extended code and lock width to a target
// register or to an error class. Purely combinational; assumes the offset
// is already relative to the core register space.
module irm_decode
    import irm_pkg::*;
(
    input  logic [OFS_W-1:0] offset,
    input  logic [3:0]       ext,
    input  logic             wide,
    output target_e          target
);
    logic is_core;
    logic is_cas;

    // Flags the core registers that exist but cannot be locked.
    always_comb begin
        is_core = offset inside {OFS_STATE_CLR, OFS_STATE_SET, OFS_NODE_IDS,
                                 OFS_RST_START, OFS_SPLIT_HI, OFS_SPLIT_LO,
                                 OFS_CYC_TIME, OFS_BUS_TIME, OFS_BCAST};
        is_cas  = (ext == EXT_CMP_SWAP);
    end

    // Picks the target for 32-bit and 64-bit requests.
    always_comb begin
        target = TGT_ADDR_ERR;
        if (offset[1:0] != 2'b00) begin
            target = TGT_TYPE_ERR;
        end else if (!wide) begin
            unique case (offset)
                OFS_MGR_ID:    target = is_cas ? TGT_MGR_ID  : TGT_TYPE_ERR;
                OFS_BANDWIDTH: target = is_cas ? TGT_BW      : TGT_TYPE_ERR;
                OFS_CHAN_HI:   target = is_cas ? TGT_CHAN_HI : TGT_TYPE_ERR;
                OFS_CHAN_LO:   target = is_cas ? TGT_CHAN_LO : TGT_TYPE_ERR;
                default:       target = is_core ? TGT_TYPE_ERR : TGT_ADDR_ERR;
            endcase
        end else begin
            if (offset == OFS_CHAN_HI)
                target = is_cas ? TGT_CHAN_PAIR : TGT_TYPE_ERR;
            else if (is_core || offset inside {OFS_MGR_ID, OFS_BANDWIDTH, OFS_BUSY_TO})
                target = TGT_TYPE_ERR;
            else
                target = TGT_ADDR_ERR;
        end
    end
endmodule

// File: rtl/irm_bw_alu.sv
// Bandwidth lock arithmetic: turns an argument/data pair into an allocation
// or a release and checks it against the current value and the range limit.
// Assumes BW_W < Q_W so that sums cannot overflow the quadlet width.
module irm_bw_alu #(
    parameter int BW_W = 13,
    parameter int Q_W  = 32
) (
    input  logic [BW_W-1:0] cur,
    input  logic [Q_W-1:0]  arg,
    input  logic [Q_W-1:0]  data,
    output logic [BW_W-1:0] nxt,
    output logic [Q_W-1:0]  ret
);
    localparam logic [Q_W-1:0] LIMIT = Q_W'(1) << BW_W;
    localparam logic [Q_W-1:0] FIELD = LIMIT - Q_W'(1);

    logic [Q_W-1:0] cur_x;
    logic [Q_W-1:0] dmask;
    logic [Q_W-1:0] amount;
    logic [Q_W-1:0] grown;

    // Evaluates the allocate or release request and chooses the outcome.
    always_comb begin
        cur_x  = Q_W'(cur);
        dmask  = data & FIELD;
        nxt    = cur;
        ret    = cur_x;
        amount = '0;
        grown  = '0;
        if (arg < LIMIT) begin
            if (arg >= dmask) begin
                amount = arg - dmask;
                if (cur_x >= amount) begin
                    nxt = BW_W'(cur_x - amount);
                    ret = arg;
                end
            end else begin
                amount = dmask - arg;
                grown  = cur_x + amount;
                if (grown < LIMIT) begin
                    nxt = BW_W'(grown);
                    ret = arg;
                end
            end
        end
    end
endmodule

// File: rtl/irm_chan_alu.sv
// Channel bitmap lock: the argument/data difference selects the affected
// bits, which are inverted only if the register agrees with the argument on
// all of them. Width chosen by W (32 for one word, 64 for the pair).
module irm_chan_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] arg,
    input  logic [W-1:0] data,
    output logic [W-1:0] nxt,
    output logic [W-1:0] ret
);
    logic [W-1:0] touched;
    logic         agree;

    // Compares the affected bits and applies the flip on agreement.
    always_comb begin
        touched = arg ^ data;
        agree   = ((arg ^ cur) & touched) == '0;
        nxt     = agree ? (cur ^ touched) : cur;
        ret     = agree ? arg : cur;
    end
endmodule

// File: rtl/irm_lock_unit.sv
// Isochronous resource lock unit: owns the bus manager ID, bandwidth and
// channel registers and performs one lock per request with a registered
// response one cycle later. Assumes requests are single-cycle pulses and
// that bus_reset takes priority over any request in the same cycle.
module irm_lock_unit
    import irm_pkg::*;
#(
    parameter int BW_W = 13,
    parameter int Q_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [3:0]        req_ext,
    input  logic [2*Q_W-1:0]  req_data,
    input  logic [2*Q_W-1:0]  req_arg,
    output logic              rsp_valid,
    output logic [3:0]        rsp_code,
    output logic [2*Q_W-1:0]  rsp_old
);
    localparam int O_W = 2 * Q_W;

    target_e         target;
    logic [Q_W-1:0]  mgr_id_q;
    logic [BW_W-1:0] bw_q;
    logic [Q_W-1:0]  chan_hi_q;
    logic [Q_W-1:0]  chan_lo_q;

    logic [BW_W-1:0] bw_nxt;
    logic [Q_W-1:0]  bw_ret;
    logic [Q_W-1:0]  word_cur;
    logic [Q_W-1:0]  word_data;
    logic [Q_W-1:0]  word_nxt;
    logic [Q_W-1:0]  word_ret;
    logic [O_W-1:0]  pair_data;
    logic [O_W-1:0]  pair_nxt;
    logic [O_W-1:0]  pair_ret;

    irm_decode u_decode (
        .offset (req_offset),
        .ext    (req_ext),
        .wide   (req_wide),
        .target (target)
    );

    irm_bw_alu #(.BW_W(BW_W), .Q_W(Q_W)) u_bw (
        .cur  (bw_q),
        .arg  (req_arg[Q_W-1:0]),
        .data (req_data[Q_W-1:0]),
        .nxt  (bw_nxt),
        .ret  (bw_ret)
    );

    // Selects the channel word and strips the reserved channel from the data.
    always_comb begin
        word_cur  = (target == TGT_CHAN_HI) ? chan_hi_q : chan_lo_q;
        word_data = req_data[Q_W-1:0];
        if (target == TGT_CHAN_HI)
            word_data[0] = 1'b0;
        pair_data     = req_data;
        pair_data[Q_W] = 1'b0;
    end

    irm_chan_alu #(.W(Q_W)) u_chan_word (
        .cur  (word_cur),
        .arg  (req_arg[Q_W-1:0]),
        .data (word_data),
        .nxt  (word_nxt),
        .ret  (word_ret)
    );

    irm_chan_alu #(.W(O_W)) u_chan_pair (
        .cur  ({chan_hi_q, chan_lo_q}),
        .arg  (req_arg),
        .data (pair_data),
        .nxt  (pair_nxt),
        .ret  (pair_ret)
    );

    // Holds the registers and issues the response one cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            mgr_id_q  <= INIT_MGR_ID[Q_W-1:0];
            bw_q      <= INIT_BW[BW_W-1:0];
            chan_hi_q <= INIT_CHAN_HI[Q_W-1:0];
            chan_lo_q <= INIT_CHAN_LO[Q_W-1:0];
            rsp_valid <= 1'b0;
            if (!rst_n) begin
                rsp_code <= RSP_DONE;
                rsp_old  <= '0;
            end
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code <= RSP_DONE;
                rsp_old  <= '0;
                unique case (target)
                    TGT_MGR_ID: begin
                        rsp_old <= O_W'(mgr_id_q);
                        if (mgr_id_q == req_arg[Q_W-1:0])
                            mgr_id_q <= req_data[Q_W-1:0];
                    end
                    TGT_BW: begin
                        rsp_old <= O_W'(bw_ret);
                        bw_q    <= bw_nxt;
                    end
                    TGT_CHAN_HI: begin
                        rsp_old   <= O_W'(word_ret);
                        chan_hi_q <= word_nxt;
                    end
                    TGT_CHAN_LO: begin
                        rsp_old   <= O_W'(word_ret);
                        chan_lo_q <= word_nxt;
                    end
                    TGT_CHAN_PAIR: begin
                        rsp_old   <= pair_ret;
                        chan_hi_q <= pair_nxt[O_W-1:Q_W];
                        chan_lo_q <= pair_nxt[Q_W-1:0];
                    end
                    TGT_TYPE_ERR: rsp_code <= RSP_TYPE_ERR;
                    default:      rsp_code <= RSP_ADDR_ERR;
                endcase
            end
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_reset) |=> rsp_valid) else $error("rsp missing"); // R1
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || bus_reset) |=> !rsp_valid) else $error("spurious rsp"); // R1
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RSP_DONE) |-> ($stable(mgr_id_q) && $stable(bw_q)
        && $stable(chan_hi_q) && $stable(chan_lo_q) && rsp_old == '0))
        else $error("error changed state"); // R3
    AST_CH31_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        chan_hi_q[0] == 1'b0) else $error("channel 31 released"); // R9
    AST_BUSRST_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (mgr_id_q == INIT_MGR_ID[Q_W-1:0] && bw_q == INIT_BW[BW_W-1:0]
        && chan_hi_q == INIT_CHAN_HI[Q_W-1:0] && chan_lo_q == INIT_CHAN_LO[Q_W-1:0]))
        else $error("bus reset values"); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !bus_reset) |=> ($stable(mgr_id_q) && $stable(bw_q)
        && $stable(chan_hi_q) && $stable(chan_lo_q))) else $error("idle change"); // R1
endmodule

// File: tb/irm_lock_unit_test.sv
// Self-checking bench: a vector table walked in order from the reset state,
// then directed checks for reset, bus reset and response timing.
module irm_lock_unit_test;
    localparam logic [11:0] A_MGR = 12'h21C;
    localparam logic [11:0] A_BW  = 12'h220;
    localparam logic [11:0] A_CHH = 12'h224;
    localparam logic [11:0] A_CHL = 12'h228;
    localparam logic [3:0]  CAS   = 4'd2;

    typedef struct packed {
        logic        wide;
        logic [11:0] ofs;
        logic [3:0]  ext;
        logic [63:0] data;
        logic [63:0] arg;
        logic [3:0]  code;
        logic [63:0] old;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0, A_MGR, CAS, 64'h05, 64'h3F, 4'd0, 64'h3F, 8'd4},             // R4 swap
        '{1'b0, A_MGR, CAS, 64'h07, 64'h3F, 4'd0, 64'h05, 8'd4},             // R4 no swap
        '{1'b0, A_BW,  CAS, 64'h0, 64'h2000, 4'd0, 64'h1333, 8'd5},          // R5 arg too big
        '{1'b0, A_BW,  CAS, 64'h1233, 64'h1333, 4'd0, 64'h1333, 8'd6},       // R6 alloc 0x100
        '{1'b0, A_BW,  CAS, 64'h0, 64'h1000, 4'd0, 64'h1000, 8'd6},          // R6 alloc 0x1000
        '{1'b0, A_BW,  CAS, 64'h0, 64'h0300, 4'd0, 64'h0233, 8'd6},          // R6 short
        '{1'b0, A_BW,  CAS, 64'h1DCD, 64'h0, 4'd0, 64'h0233, 8'd7},          // R7 hits limit
        '{1'b0, A_BW,  CAS, 64'h1DCC, 64'h0, 4'd0, 64'h0, 8'd7},             // R7 free to 0x1FFF
        '{1'b0, A_BW,  CAS, 64'hFFFFE010, 64'h10, 4'd0, 64'h10, 8'd5},       // R5 data masked
        '{1'b0, A_BW,  CAS, 64'h0, 64'h2000, 4'd0, 64'h1FFF, 8'd7},          // R7 probe
        '{1'b0, A_CHL, CAS, 64'h7FFFFFFF, 64'hFFFFFFFF, 4'd0, 64'hFFFFFFFF, 8'd8}, // R8 take
        '{1'b0, A_CHL, CAS, 64'h7FFFFFFF, 64'hFFFFFFFF, 4'd0, 64'h7FFFFFFF, 8'd8}, // R8 busy
        '{1'b0, A_CHH, CAS, 64'hFFFFFFF0, 64'hFFFFFFFE, 4'd0, 64'hFFFFFFFE, 8'd8}, // R8 high
        '{1'b0, A_CHH, CAS, 64'hFFFFFFF1, 64'hFFFFFFF0, 4'd0, 64'hFFFFFFF0, 8'd9}, // R9 release 31
        '{1'b0, A_CHH, CAS, 64'h0, 64'h1, 4'd0, 64'hFFFFFFF0, 8'd9},         // R9 probe
        '{1'b1, A_CHH, CAS, 64'hFFFFFFFE_7FFFFFFF, 64'hFFFFFFF0_7FFFFFFF, 4'd0,
          64'hFFFFFFF0_7FFFFFFF, 8'd10},                                     // R10 pair
        '{1'b1, A_CHH, CAS, 64'h0, 64'h1_00000000, 4'd0, 64'hFFFFFFFE_7FFFFFFF, 8'd12}, // R12
        '{1'b1, A_CHH, CAS, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFE_7FFFFFFF, 4'd0,
          64'hFFFFFFFE_7FFFFFFF, 8'd9},                                      // R9 wide release
        '{1'b1, A_CHH, CAS, 64'h0, 64'h1_00000000, 4'd0, 64'hFFFFFFFE_FFFFFFFF, 8'd9}, // R9 probe
        '{1'b0, A_BW,  4'd1, 64'h0, 64'h0, 4'd6, 64'h0, 8'd3},               // R3 wrong code
        '{1'b0, 12'h008, CAS, 64'h0, 64'h0, 4'd6, 64'h0, 8'd3},              // R3 core reg
        '{1'b0, 12'h210, CAS, 64'h0, 64'h0, 4'd7, 64'h0, 8'd3},              // R3 busy timeout
        '{1'b0, 12'h300, CAS, 64'h0, 64'h0, 4'd7, 64'h0, 8'd3},              // R3 unknown
        '{1'b0, 12'h222, CAS, 64'h0, 64'h0, 4'd6, 64'h0, 8'd2},              // R2 misaligned
        '{1'b1, A_CHL, CAS, 64'h0, 64'h0, 4'd7, 64'h0, 8'd10},               // R10 wide low
        '{1'b1, A_BW,  CAS, 64'h0, 64'h0, 4'd6, 64'h0, 8'd10},               // R10 wide bw
        '{1'b1, A_MGR, CAS, 64'h0, 64'h05, 4'd6, 64'h0, 8'd10},              // R10 wide mgr
        '{1'b0, A_MGR, CAS, 64'h0, 64'h0, 4'd0, 64'h05, 8'd3}                // R3 mgr kept
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic [11:0] req_offset = '0;
    logic [3:0]  req_ext = '0;
    logic [63:0] req_data = '0;
    logic [63:0] req_arg = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_code;
    logic [63:0] rsp_old;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    irm_lock_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_wide(req_wide), .req_offset(req_offset),
        .req_ext(req_ext), .req_data(req_data), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_old(rsp_old)
    );

    task automatic chk(input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Drives one request on a falling edge, reads the response one cycle later.
    task automatic lock(input logic wide, input logic [11:0] ofs, input logic [3:0] ext,
                        input logic [63:0] data, input logic [63:0] arg,
                        input logic [3:0] code, input logic [63:0] old, input int rq);
        @(negedge clk);
        req_valid = 1'b1; req_wide = wide; req_offset = ofs;
        req_ext = ext; req_data = data; req_arg = arg;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rq, "rsp_code", 64'(rsp_code), 64'(code));
        chk(rq, "rsp_old", rsp_old, old);
    endtask

    // Reads all four registers through locks that cannot change them (R11).
    task automatic probe_initial(input string when);
        lock(1'b0, A_MGR, CAS, 64'h0, 64'h0, 4'd0, 64'h3F, 11);
        lock(1'b0, A_BW, CAS, 64'h0, 64'h2000, 4'd0, 64'h1333, 11);
        lock(1'b1, A_CHH, CAS, 64'h0, 64'h1_00000000, 4'd0, 64'hFFFFFFFE_FFFFFFFF, 11);
        $display("probed initial state %s", when);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(11, "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(11, "reset rsp_code", 64'(rsp_code), 64'd0);
        chk(12, "reset rsp_old", rsp_old, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "idle no response", 64'(rsp_valid), 64'd0);
        probe_initial("after reset");

        for (int i = 0; i < NV; i++) begin
            lock(VEC[i].wide, VEC[i].ofs, VEC[i].ext, VEC[i].data, VEC[i].arg,
                 VEC[i].code, VEC[i].old, int'(VEC[i].rq));
        end

        // R1: response is a single-cycle pulse
        @(negedge clk);
        chk(1, "pulse ends", 64'(rsp_valid), 64'd0);

        // R11 / R1: request together with bus reset gets no response, state restored
        @(negedge clk);
        bus_reset = 1'b1; req_valid = 1'b1; req_wide = 1'b0;
        req_offset = A_MGR; req_ext = CAS; req_data = 64'h9; req_arg = 64'h5;
        @(negedge clk);
        bus_reset = 1'b0; req_valid = 1'b0;
        chk(1, "no rsp under bus reset", 64'(rsp_valid), 64'd0);
        probe_initial("after bus reset");

        // R2: compare-swap on the low channel word at the boundary of the range
        lock(1'b0, A_CHL, CAS, 64'hFFFFFFFE, 64'hFFFFFFFF, 4'd0, 64'hFFFFFFFF, 2);
        lock(1'b0, A_CHL, CAS, 64'h0, 64'h0, 4'd0, 64'h0, 2);
        lock(1'b1, A_CHH, CAS, 64'h0, 64'h1_00000000, 4'd0, 64'hFFFFFFFE_FFFFFFFE, 2);
        // R3: broadcast register is a core register
        lock(1'b0, 12'h234, CAS, 64'h0, 64'h0, 4'd6, 64'h0, 3);
        // R10: wide lock with wrong code at the high word
        lock(1'b1, A_CHH, 4'd1, 64'h0, 64'h0, 4'd6, 64'h0, 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule